// File: doc/BRIEF.md
# Dual-Channel Baseline Drift Compensator

This block tracks a slowly moving baseline for two capacitive sensing channels. Each channel holds a 16-bit reference level that follows the measured sample one count at a time. Two interval timers set the pace, and both channels share them. One timer paces upward tracking and the other paces downward tracking. Each timer has its own 8-bit rate setting. The reference therefore follows slow environmental drift, while a fast change such as an approaching finger stays visible as a deviation.

An interval counts whole burst spacings. When the spacing count is nonzero, one spacing is that many base ticks. When the spacing count is zero, the block counts burst-duration ticks instead and scales the count by 16. A rate code of 255 turns its direction off. A recalibrate input snaps every reference to its current sample and restarts both timers. On every burst-complete strobe the block publishes a signed deviation (sample minus reference) for each channel.

Top module: `baseline_drift_comp`

## Requirements
- R1: After reset both references and both deviations are 0, the upward rate setting is 100 and the downward rate setting is 2.
- R2: A cycle with `cfg_load` high latches `up_rate_in` and `down_rate_in` as the new rate settings for all later intervals.
- R3: With `spacing` = S > 0 and a rate setting N < 255, that direction's interval elapses on base tick number (N+1)*S counted from reset, recalibration or the previous interval.
- R4: With `spacing` = 0 the interval elapses on burst-duration tick number (N+1)*16, and base ticks do not advance it.
- R5: A rate setting of 255 disables its direction, so no reference moves in that direction however many ticks arrive.
- R6: When the upward interval elapses, each channel whose sample is strictly above its reference raises that reference by exactly one. No other channel changes.
- R7: When the downward interval elapses, each channel whose sample is strictly below its reference lowers that reference by exactly one. A channel whose sample equals its reference does not move.
- R8: Both channels use the same two interval timers, so they step on the same tick.
- R9: `recal` loads each reference with that channel's sample on the next edge and restarts both interval timers from zero.
- R10: On `burst_done` each `deviation` becomes sample minus reference as a 17-bit two's-complement value. Between strobes it holds its value.
- R11: A reference never steps past its sample and stays within 0 to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recal | input | 1 | Load references from samples and restart timers |
| burst_done | input | 1 | Burst-complete strobe that updates deviations |
| base_tick | input | 1 | Base time tick, counted when spacing is nonzero |
| dur_tick | input | 1 | Burst-duration tick, counted when spacing is zero |
| spacing | input | 8 | Base ticks per burst spacing; 0 selects duration-tick scaling |
| cfg_load | input | 1 | Latch the two rate settings |
| up_rate_in | input | 8 | Upward interval setting (255 disables) |
| down_rate_in | input | 8 | Downward interval setting (255 disables) |
| sample | input | 2x16 | Measured sample per channel |
| ref_level | output | 2x16 | Reference level per channel |
| deviation | output | 2x17 | Signed sample minus reference per channel |

## Verification
A table of spacing and rate pairs drives a channel upward. The check samples the reference one tick before the expected step and again on the step tick, so an error of one tick in the (N+1)*S product or in the times-16 scaling shows up. The default settings are tested with one channel above its reference and one below. Upward and downward steps on the same ticks separate the two timers from each other and show that the channels share them. Other directed runs cover:
- stray base ticks in duration mode
- a disabled code with a long tick run
- equal sample and reference
- a recalibration between intervals
- references pinned at 0 and 65535
- deviation sign and the full-scale value

// File: rtl/drift_pkg.sv
package drift_pkg;
   localparam int unsigned DRIFT_DIRS = 2;
   typedef enum logic [0:0] {
      DIR_RISE = 1'b0,
      DIR_FALL = 1'b1
   } drift_dir_e;
   typedef struct packed {
      logic rise;
      logic fall;
   } drift_step_t;
endpackage

// File: rtl/drift_interval_timer.sv
module drift_interval_timer #(
   parameter int unsigned SW  = 8,
   parameter int unsigned SCW = 8,
   parameter int unsigned OFF_CODE = 255
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           restart,
   input  logic [SW-1:0]  setting,
   input  logic [SCW-1:0] spacing,
   input  logic           base_tick,
   input  logic           dur_tick,
   output logic           fire
);
   localparam int unsigned TW = SW + 5;

   generate
      if (SW < 2 || SCW < 1) begin : g_bad_width
         $error("drift_interval_timer: widths too small");
      end
      if (OFF_CODE >= (1 << SW)) begin : g_bad_code
         $error("drift_interval_timer: OFF_CODE out of range");
      end
   endgenerate

   logic [SCW-1:0] sub_q;
   logic [TW-1:0]  unit_q;
   logic           enabled, scaled, unit_ev;
   logic [TW-1:0]  target;

   always_comb begin
      enabled = (setting != SW'(OFF_CODE));
      scaled  = (spacing == '0);
      target  = TW'(setting) + TW'(1);
      if (scaled) target = target << 4;
      if (scaled) unit_ev = dur_tick;
      else        unit_ev = base_tick && (sub_q >= spacing - SCW'(1));
      fire = enabled && unit_ev && (unit_q >= target - TW'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !enabled) begin
         sub_q  <= '0;
         unit_q <= '0;
      end else begin
         if (scaled)         sub_q <= '0;
         else if (base_tick) sub_q <= (sub_q >= spacing - SCW'(1)) ? '0 : sub_q + SCW'(1);
         if (unit_ev)        unit_q <= fire ? '0 : unit_q + TW'(1);
      end
   end

   a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (setting == SW'(OFF_CODE)) |-> !fire);
   a_r4_needs_duration_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && spacing == '0) |-> dur_tick);
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (unit_q == '0 && sub_q == '0));
endmodule

// File: rtl/drift_channel.sv
module drift_channel #(
   parameter int unsigned W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                recal,
   input  logic                burst_done,
   input  logic [W-1:0]        sample,
   input  drift_pkg::drift_step_t step,
   output logic [W-1:0]        ref_o,
   output logic signed [W:0]   dev_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("drift_channel: W too small");
      end
   endgenerate

   logic [W-1:0] ref_q;
   logic signed [W:0] dev_q;
   logic above, below;

   always_comb begin
      above = sample > ref_q;
      below = sample < ref_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= '0;
      end else if (recal) begin
         ref_q <= sample;
      end else if (step.rise && above && ref_q != '1) begin
         ref_q <= ref_q + W'(1);
      end else if (step.fall && below && ref_q != '0) begin
         ref_q <= ref_q - W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          dev_q <= '0;
      else if (burst_done) dev_q <= $signed({1'b0, sample}) - $signed({1'b0, ref_q});
   end

   assign ref_o = ref_q;
   assign dev_o = dev_q;

   a_r6_rise_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!recal && step.rise && above) |=> ref_q == $past(ref_q) + W'(1));
   a_r7_fall_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!recal && step.fall && below) |=> ref_q == $past(ref_q) - W'(1));
   a_r7_equal_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!recal && sample == ref_q) |=> $stable(ref_q));
   a_r9_recal_loads: assert property (@(posedge clk) disable iff (!rst_n)
      recal |=> ref_q == $past(sample));
   a_r11_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!recal && !step.rise && !step.fall) |=> $stable(ref_q));
   a_r10_dev_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_done |=> $stable(dev_q));
endmodule

// File: rtl/baseline_drift_comp.sv
module baseline_drift_comp #(
   parameter int unsigned NCH  = 2,
   parameter int unsigned W    = 16,
   parameter int unsigned SW   = 8,
   parameter int unsigned SCW  = 8,
   parameter int unsigned RISE_DEFAULT = 100,
   parameter int unsigned FALL_DEFAULT = 2,
   parameter int unsigned OFF_CODE     = 255
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       recal,
   input  logic                       burst_done,
   input  logic                       base_tick,
   input  logic                       dur_tick,
   input  logic [SCW-1:0]             spacing,
   input  logic                       cfg_load,
   input  logic [SW-1:0]              up_rate_in,
   input  logic [SW-1:0]              down_rate_in,
   input  logic [NCH-1:0][W-1:0]      sample,
   output logic [NCH-1:0][W-1:0]      ref_level,
   output logic [NCH-1:0][W:0]        deviation
);
   import drift_pkg::*;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("baseline_drift_comp: NCH must be at least 1");
      end
      if (RISE_DEFAULT >= (1 << SW) || FALL_DEFAULT >= (1 << SW)) begin : g_bad_def
         $error("baseline_drift_comp: default rate does not fit SW");
      end
   endgenerate

   logic [DRIFT_DIRS-1:0][SW-1:0] rate_q;
   logic [DRIFT_DIRS-1:0]         fire;
   drift_step_t                   step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q[DIR_RISE] <= SW'(RISE_DEFAULT);
         rate_q[DIR_FALL] <= SW'(FALL_DEFAULT);
      end else if (cfg_load) begin
         rate_q[DIR_RISE] <= up_rate_in;
         rate_q[DIR_FALL] <= down_rate_in;
      end
   end

   genvar d, c;
   generate
      for (d = 0; d < DRIFT_DIRS; d++) begin : g_dir
         drift_interval_timer #(.SW(SW), .SCW(SCW), .OFF_CODE(OFF_CODE)) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (recal),
            .setting   (rate_q[d]),
            .spacing   (spacing),
            .base_tick (base_tick),
            .dur_tick  (dur_tick),
            .fire      (fire[d])
         );
      end
   endgenerate

   always_comb begin
      step.rise = fire[DIR_RISE];
      step.fall = fire[DIR_FALL];
   end

   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         logic signed [W:0] dev_c;
         drift_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .recal      (recal),
            .burst_done (burst_done),
            .sample     (sample[c]),
            .step       (step),
            .ref_o      (ref_level[c]),
            .dev_o      (dev_c)
         );
         assign deviation[c] = dev_c;
      end
   endgenerate

   a_r2_rates_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(rate_q));
   a_r2_rates_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (rate_q[DIR_RISE] == $past(up_rate_in) && rate_q[DIR_FALL] == $past(down_rate_in)));
endmodule

// File: tb/test_baseline_drift_comp.sv
module test_baseline_drift_comp;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic recal = 1'b0, burst_done = 1'b0, base_tick = 1'b0, dur_tick = 1'b0, cfg_load = 1'b0;
   logic [7:0] spacing = 8'd1, up_rate_in = '0, down_rate_in = '0;
   logic [1:0][15:0] sample = '0;
   logic [1:0][15:0] ref_level;
   logic [1:0][16:0] deviation;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   baseline_drift_comp i_baseline_drift_comp (
      .clk(clk), .rst_n(rst_n), .recal(recal), .burst_done(burst_done),
      .base_tick(base_tick), .dur_tick(dur_tick), .spacing(spacing),
      .cfg_load(cfg_load), .up_rate_in(up_rate_in), .down_rate_in(down_rate_in),
      .sample(sample), .ref_level(ref_level), .deviation(deviation)
   );

   typedef struct packed {
      logic [7:0]  sc;
      logic [7:0]  rate;
      logic [15:0] ticks;
   } vec_t;
   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{8'd3, 8'd2, 16'd9},
      '{8'd1, 8'd0, 16'd1},
      '{8'd5, 8'd1, 16'd10},
      '{8'd2, 8'd6, 16'd14},
      '{8'd0, 8'd0, 16'd16},
      '{8'd0, 8'd1, 16'd32}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input bit dur);
      @(negedge clk);
      base_tick = !dur;
      dur_tick  = dur;
      @(negedge clk);
      base_tick = 1'b0;
      dur_tick  = 1'b0;
   endtask

   task automatic ticks(input int n, input bit dur);
      for (int i = 0; i < n; i++) tick(dur);
   endtask

   task automatic do_recal(input int a, input int b);
      @(negedge clk);
      sample[0] = 16'(a);
      sample[1] = 16'(b);
      recal = 1'b1;
      @(negedge clk);
      recal = 1'b0;
   endtask

   task automatic do_cfg(input int up, input int dn);
      @(negedge clk);
      up_rate_in = 8'(up);
      down_rate_in = 8'(dn);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      burst_done = 1'b1;
      @(negedge clk);
      burst_done = 1'b0;
   endtask

   function automatic int dev(input int c);
      return int'($signed(deviation[c]));
   endfunction

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ref0", int'(ref_level[0]), 0);
      check("R1 ref1", int'(ref_level[1]), 0);
      check("R1 dev0", dev(0), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: default settings, rise=100 and fall=2, spacing 1
      spacing = 8'd1;
      do_recal(500, 500);
      sample[0] = 16'd400;
      sample[1] = 16'd600;
      ticks(2, 1'b0);
      check("R1 fall default before", int'(ref_level[0]), 500);
      tick(1'b0);
      check("R1 fall default step", int'(ref_level[0]), 499);
      ticks(97, 1'b0);
      check("R1 rise default before", int'(ref_level[1]), 500);
      tick(1'b0);
      check("R1 rise default step", int'(ref_level[1]), 501);
      check("R1 fall cadence", int'(ref_level[0]), 467);

      // R3 R4 R8 R2: vector table, upward only
      for (int v = 0; v < NV; v++) begin
         do_cfg(int'(VECS[v].rate), 255);
         spacing = VECS[v].sc;
         do_recal(1000, 2000);
         sample[0] = 16'd3000;
         sample[1] = 16'd3000;
         ticks(int'(VECS[v].ticks) - 1, VECS[v].sc == 8'd0);
         check(VECS[v].sc == 0 ? "R4 before step" : "R3 before step", int'(ref_level[0]), 1000);
         tick(VECS[v].sc == 8'd0);
         check(VECS[v].sc == 0 ? "R4 step" : "R3 step", int'(ref_level[0]), 1001);
         check("R8 shared timer", int'(ref_level[1]), 2001);
      end

      // R4: base ticks ignored in duration mode
      do_cfg(0, 255);
      spacing = 8'd0;
      do_recal(100, 100);
      sample[0] = 16'd200;
      ticks(40, 1'b0);
      check("R4 base ticks ignored", int'(ref_level[0]), 100);
      ticks(16, 1'b1);
      check("R4 duration step", int'(ref_level[0]), 101);

      // R5: both directions disabled
      do_cfg(255, 255);
      spacing = 8'd1;
      do_recal(300, 300);
      sample[0] = 16'd900;
      sample[1] = 16'd10;
      ticks(300, 1'b0);
      check("R5 rise disabled", int'(ref_level[0]), 300);
      check("R5 fall disabled", int'(ref_level[1]), 300);

      // R6 R7 R8: opposite directions on shared ticks, equal sample holds
      do_cfg(0, 0);
      do_recal(50, 50);
      sample[0] = 16'd60;
      sample[1] = 16'd40;
      ticks(4, 1'b0);
      check("R6 rise by one per interval", int'(ref_level[0]), 54);
      check("R7 fall by one per interval", int'(ref_level[1]), 46);
      do_recal(70, 70);
      ticks(5, 1'b0);
      check("R7 equal sample holds", int'(ref_level[0]), 70);
      check("R6 equal sample holds", int'(ref_level[1]), 70);

      // R9: recalibration restarts the timer
      do_cfg(255, 2);
      do_recal(800, 800);
      sample[0] = 16'd700;
      ticks(2, 1'b0);
      do_recal(800, 800);
      check("R9 recal loads", int'(ref_level[1]), 800);
      sample[0] = 16'd700;
      ticks(2, 1'b0);
      check("R9 restart before", int'(ref_level[0]), 800);
      tick(1'b0);
      check("R9 restart step", int'(ref_level[0]), 799);

      // R11: saturation and stopping at the sample
      do_cfg(0, 0);
      do_recal(2, 65534);
      sample[0] = 16'd0;
      sample[1] = 16'd65535;
      ticks(2, 1'b0);
      check("R11 reach zero", int'(ref_level[0]), 0);
      check("R11 reach max", int'(ref_level[1]), 65535);
      ticks(3, 1'b0);
      check("R11 stay zero", int'(ref_level[0]), 0);
      check("R11 stay max", int'(ref_level[1]), 65535);

      // R10: deviation sign, hold and full scale
      do_cfg(255, 255);
      do_recal(1000, 1000);
      sample[0] = 16'd900;
      sample[1] = 16'd1250;
      strobe();
      check("R10 negative", dev(0), -100);
      check("R10 positive", dev(1), 250);
      sample[0] = 16'd5;
      repeat (3) @(negedge clk);
      check("R10 hold", dev(0), -100);
      do_recal(0, 65535);
      sample[0] = 16'd65535;
      sample[1] = 16'd0;
      strobe();
      check("R10 full scale up", dev(0), 65535);
      check("R10 full scale down", dev(1), -65535);

      report();
   end
endmodule